// File: doc/BRIEF.md
# DRAM Bank Timing Sequencer

This block sits between a request source and one DRAM bank. Each request carries a read/write flag, a row address and a column address, and enters through a valid/ready handshake. The block keeps at most one row open and remembers which row that is. A request to the open row (a hit) goes straight to a column command. A request to some other row (a miss) first closes the open row with a precharge, then activates the new row, and only then issues the column command. When no row is open, a request activates directly, with no precharge.

The timing values are run-time inputs counted in clock cycles. They cover the column-to-data latency, the activate-to-column gap, the precharge-to-activate gap and the minimum time a row stays open before it may be precharged. A command-rate input selects single-cycle or two-cycle command spacing. The block has four named states. IDLE means no row is open and a request is accepted (transition "open-new", pending ACT). OPEN means a row is open and a request is accepted (transition "hit", pending column command, or "miss", pending PRE). WAIT holds a pending command until its gap timer has expired (transition "fire", or "select" in two-cycle mode). SEL is the select cycle of two-cycle mode (transition "fire"). A fired PRE moves on to a pending ACT, a fired ACT moves on to a pending column command, and a fired column command returns to OPEN.

A read is marked by a one-cycle read-valid pulse that comes exactly the programmed column latency after the read command. A timing value of zero is taken as one, so two dependent commands never share a cycle.

Top module: `dram_bank_seq`

## Requirements
- R1: During and straight after reset the command bus shows NOP (command encoding: NOP=0, ACT=1, RD=2, WR=3, PRE=4), chip-select (cs_n, active low) is high, req_ready is high, rd_valid is low, and no row is open.
- R2: A request accepted with no row open issues ACT first, with no PRE. In single-cycle mode the ACT comes in the cycle after acceptance.
- R3: A column command (RD or WR) after an ACT issues in the first cycle at least tRCD cycles after the ACT, plus one cycle in two-cycle mode.
- R4: rd_valid is high for exactly one cycle, CL cycles after each RD command, and never follows a WR.
- R5: A PRE issues no earlier than tRAS cycles after the ACT of the row it closes. When a request arrives after that point it issues at once (in the cycle after acceptance, plus one cycle in two-cycle mode).
- R6: An ACT that follows a PRE issues exactly tRP cycles after the PRE, plus one cycle in two-cycle mode.
- R7: A request to the open row issues its column command in the cycle after acceptance (one cycle later in two-cycle mode), with no ACT or PRE.
- R8: A request to a row other than the open one issues PRE, ACT and the column command in that order, and the new row becomes the open row.
- R9: In single-cycle mode cs_n is low only in cycles that carry a command. In two-cycle mode cs_n is also low in the cycle just before each command, and that cycle carries NOP.
- R10: A timing value of 0 behaves exactly like a value of 1.
- R11: req_ready is low from the cycle after a request is accepted up to and including the cycle of its column command, and high again in the next cycle.
- R12: cmd_row carries the request's row in an ACT cycle, and cmd_col carries its column in a RD or WR cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cl | input | TW | Read command to data-valid latency in cycles |
| cfg_trcd | input | TW | ACT to column command gap in cycles |
| cfg_trp | input | TW | PRE to ACT gap in cycles |
| cfg_tras | input | TW | ACT to PRE minimum in cycles |
| cfg_cmd2t | input | 1 | 1 selects two-cycle command spacing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| cmd_o | output | 3 | Encoded command for this cycle |
| cmd_row | output | ROW_W | Row address that goes with ACT |
| cmd_col | output | COL_W | Column address that goes with RD/WR |
| cs_n | output | 1 | Chip select, active low |
| rd_valid | output | 1 | Read data valid pulse |

## Verification
The bench predicts every command cycle from the timing rules for three request shapes: a request with no row open, a request to the open row, and a request to another row. A mismatch points to the wrong path being taken or to a miscounted gap. Directed runs use a slow tRAS, so a miss is held back by the open-row minimum, and an all-zero configuration, which separates the zero-as-one rule from an off-by-one in the counters. Random runs draw rows from a small set so that hits and misses mix with idle gaps of varied length, and each run is done in both command-rate modes. This exposes a select cycle that is missing or misplaced, and read-valid pulses that come at the wrong time when reads and writes are interleaved.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } dbs_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_WAIT,
        ST_SEL
    } dbs_state_e;

    localparam int TMR_RCD = 0;
    localparam int TMR_RAS = 1;
    localparam int TMR_RP  = 2;
    localparam int NUM_TMR = 3;

endpackage

// File: rtl/dbs_gap_timer.sv
module dbs_gap_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] span,
    output logic          expired
);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] span_eff;

    // a zero span counts as one cycle
    assign span_eff = (span == '0) ? TW'(1) : span;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= span_eff - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R10: a zero or unit span lets the dependent command go in the very next cycle
    p_zero_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (span <= TW'(1))) |=> expired);

    // R3 R5 R6: a span of two or more holds the gate shut in the next cycle
    p_span_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (span > TW'(1))) |=> !expired);

endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_fire,
    input  logic             close_fire,
    input  logic [ROW_W-1:0] new_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             row_open,
    output logic             probe_hit
);

    logic [ROW_W-1:0] open_row_q;
    logic             open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_row_q <= '0;
        end else if (open_fire) begin
            open_q     <= 1'b1;
            open_row_q <= new_row;
        end else if (close_fire) begin
            open_q     <= 1'b0;
        end
    end

    assign row_open  = open_q;
    assign probe_hit = open_q && (open_row_q == probe_row);

    // R8: a precharge only ever closes a row that is open
    p_pre_needs_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        close_fire |-> open_q);

    // R2: an activate only happens with the bank closed
    p_act_needs_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        open_fire |-> !open_q);

endmodule

// File: rtl/dbs_lat_pipe.sv
module dbs_lat_pipe #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [TW-1:0] lat,
    output logic          valid_o
);

    localparam int DEPTH = (1 << TW) - 1;

    logic [DEPTH-1:0] shift_q;
    logic [TW-1:0]    tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[DEPTH-2:0], fire};
        end
    end

    // zero latency is taken as one
    assign tap     = ((lat == '0) ? TW'(1) : lat) - TW'(1);
    assign valid_o = shift_q[tap];

    // R4: the pulse lasts one cycle because reads are never back to back
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dbs_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_cl,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_tras,
    input  logic             cfg_cmd2t,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic [2:0]       cmd_o,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             cs_n,
    output logic             rd_valid
);

    localparam int SW = TW + 1;

    dbs_state_e       state_q, state_d;
    dbs_cmd_e         pend_q, pend_d;
    logic [ROW_W-1:0] lat_row_q;
    logic [COL_W-1:0] lat_col_q;
    logic             lat_wr_q;

    logic             accept;
    logic             gate_ok;
    logic             issue;
    logic             is_col;
    dbs_cmd_e         col_cmd;
    dbs_cmd_e         cur_cmd;
    logic             act_fire, pre_fire, rd_fire;
    logic             row_open, hit;

    logic [NUM_TMR-1:0] tmr_load;
    logic [NUM_TMR-1:0] tmr_done;
    logic [TW-1:0]      tmr_span [NUM_TMR];

    // ---------------- handshake and request latch ----------------
    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_OPEN);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_row_q <= '0;
            lat_col_q <= '0;
            lat_wr_q  <= 1'b0;
        end else if (accept) begin
            lat_row_q <= req_row;
            lat_col_q <= req_col;
            lat_wr_q  <= req_write;
        end
    end

    assign col_cmd = lat_wr_q ? CMD_WR : CMD_RD;

    // ---------------- gap timers ----------------
    assign tmr_load[TMR_RCD] = act_fire;
    assign tmr_load[TMR_RAS] = act_fire;
    assign tmr_load[TMR_RP]  = pre_fire;
    assign tmr_span[TMR_RCD] = cfg_trcd;
    assign tmr_span[TMR_RAS] = cfg_tras;
    assign tmr_span[TMR_RP]  = cfg_trp;

    generate
        for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
            dbs_gap_timer #(.TW(TW)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (tmr_load[g]),
                .span    (tmr_span[g]),
                .expired (tmr_done[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (pend_q)
            CMD_PRE: gate_ok = tmr_done[TMR_RAS];
            CMD_ACT: gate_ok = tmr_done[TMR_RP];
            CMD_RD,
            CMD_WR:  gate_ok = tmr_done[TMR_RCD];
            default: gate_ok = 1'b0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= CMD_ACT;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign issue = ((state_q == ST_WAIT) && gate_ok && !cfg_cmd2t) || (state_q == ST_SEL);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin           // open-new
                    state_d = ST_WAIT;
                    pend_d  = CMD_ACT;
                end
            end
            ST_OPEN: begin
                if (accept) begin           // hit or miss
                    state_d = ST_WAIT;
                    pend_d  = hit ? (req_write ? CMD_WR : CMD_RD) : CMD_PRE;
                end
            end
            ST_WAIT: begin
                if (gate_ok && cfg_cmd2t) begin   // select
                    state_d = ST_SEL;
                end
            end
            ST_SEL: begin
                state_d = ST_SEL;           // left by fire below
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (issue) begin                    // fire
            unique case (pend_q)
                CMD_PRE: begin
                    state_d = ST_WAIT;
                    pend_d  = CMD_ACT;
                end
                CMD_ACT: begin
                    state_d = ST_WAIT;
                    pend_d  = col_cmd;
                end
                default: begin
                    state_d = ST_OPEN;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cur_cmd = issue ? pend_q : CMD_NOP;
        is_col  = (cur_cmd == CMD_RD) || (cur_cmd == CMD_WR);
        cmd_o   = cur_cmd;
        cmd_row = (cur_cmd == CMD_ACT) ? lat_row_q : '0;
        cmd_col = is_col ? lat_col_q : '0;
        cs_n    = !(issue || ((state_q == ST_WAIT) && gate_ok && cfg_cmd2t));
    end

    assign act_fire = (cur_cmd == CMD_ACT);
    assign pre_fire = (cur_cmd == CMD_PRE);
    assign rd_fire  = (cur_cmd == CMD_RD);

    // ---------------- open row and read latency ----------------
    dbs_row_track #(.ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_fire  (act_fire),
        .close_fire (pre_fire),
        .new_row    (lat_row_q),
        .probe_row  (req_row),
        .row_open   (row_open),
        .probe_hit  (hit)
    );

    dbs_lat_pipe #(.TW(TW)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (rd_fire),
        .lat     (cfg_cl),
        .valid_o (rd_valid)
    );

    // ---------------- assertions ----------------
    function automatic logic [SW-1:0] eff_w(input logic [TW-1:0] v);
        return {1'b0, ((v == '0) ? TW'(1) : v)};
    endfunction

    logic [SW-1:0] since_act_q, since_pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_act_q <= '1;
            since_pre_q <= '1;
        end else begin
            since_act_q <= act_fire ? SW'(1) :
                           ((since_act_q == '1) ? since_act_q : since_act_q + SW'(1));
            since_pre_q <= pre_fire ? SW'(1) :
                           ((since_pre_q == '1) ? since_pre_q : since_pre_q + SW'(1));
        end
    end

    p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act_q >= eff_w(cfg_trcd)));

    p_ras_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |-> (since_act_q >= eff_w(cfg_tras)));

    p_rp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> (since_pre_q >= eff_w(cfg_trp)));

    p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !row_open);

    p_cs_with_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 3'(CMD_NOP)) |-> !cs_n);

    p_sel_before_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmd2t && (cmd_o != 3'(CMD_NOP))) |-> ($past(!cs_n) && ($past(cmd_o) == 3'(CMD_NOP))));

    p_busy_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n) |-> !req_ready);

endmodule

// File: tb/dram_bank_seq_bench.sv
module dram_bank_seq_bench;
    import dbs_pkg::*;

    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int TW    = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [TW-1:0]    cfg_cl, cfg_trcd, cfg_trp, cfg_tras;
    logic             cfg_cmd2t;
    logic             req_valid, req_ready, req_write;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [2:0]       cmd_o;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             cs_n, rd_valid;

    always #4 clk = ~clk;   // 125 MHz

    dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_dram_bank_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cfg_cmd2t(cfg_cmd2t),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col),
        .cmd_o(cmd_o), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cs_n(cs_n), .rd_valid(rd_valid)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    cyc     = 0;
    bit    in_rst  = 1'b1;
    string cur_tag = "R1";
    string ptag    = "";

    int               exp_pre, exp_act, exp_col, acc_cyc;
    logic [2:0]       exp_colcmd;
    logic [ROW_W-1:0] exp_row;
    logic [COL_W-1:0] exp_colv;
    int               due_q[$];
    bit               m_open;
    logic [ROW_W-1:0] m_row;
    int               m_last_act;

    function automatic int eff(input logic [TW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string tag, input string what, input longint got, input longint want);
        vectors++;
        if (got != want) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, got, want);
        end
    endtask

    task automatic step();
        logic [2:0] e_cmd;
        bit         e_cs_low, e_rdv, e_rdy;
        @(negedge clk);
        cyc++;
        if (!in_rst) begin
            e_cmd = 3'(CMD_NOP);
            if (cyc == exp_pre) e_cmd = 3'(CMD_PRE);
            if (cyc == exp_act) e_cmd = 3'(CMD_ACT);
            if (cyc == exp_col) e_cmd = exp_colcmd;
            chk({ptag, cur_tag}, "cmd", cmd_o, e_cmd);
            e_cs_low = (e_cmd != 3'(CMD_NOP)) ||
                       (cfg_cmd2t && ((cyc + 1 == exp_pre) || (cyc + 1 == exp_act) || (cyc + 1 == exp_col)));
            chk("R9", "cs_n", cs_n, !e_cs_low);
            e_rdv = (due_q.size() > 0) && (due_q[0] == cyc);
            if (e_rdv) void'(due_q.pop_front());
            chk("R4", "rd_valid", rd_valid, e_rdv);
            e_rdy = !((cyc > acc_cyc) && (cyc <= exp_col));
            chk("R11", "req_ready", req_ready, e_rdy);
            if (e_cmd == 3'(CMD_ACT)) chk("R12", "cmd_row", cmd_row, exp_row);
            if (cyc == exp_col)       chk("R12", "cmd_col", cmd_col, exp_colv);
        end
    endtask

    task automatic do_reset();
        in_rst    = 1'b1;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (3) step();
        // R1: reset state seen while reset is held
        chk("R1", "cmd in reset", cmd_o, 3'(CMD_NOP));
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "ready in reset", req_ready, 1);
        chk("R1", "rd_valid in reset", rd_valid, 0);
        rst_n      = 1'b1;
        exp_pre    = -1;
        exp_act    = -1;
        exp_col    = -1;
        acc_cyc    = -1;
        exp_colcmd = 3'(CMD_NOP);
        due_q.delete();
        m_open     = 1'b0;
        m_row      = '0;
        m_last_act = -100;
        in_rst     = 1'b0;
        cur_tag    = "R1";
        step();
        step();
    endtask

    task automatic do_req(input bit wr, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        int c, entry, ex;
        step();
        req_valid = 1'b1;
        req_write = wr;
        req_row   = row;
        req_col   = col;
        c         = cyc;
        acc_cyc   = c;
        ex        = cfg_cmd2t ? 1 : 0;
        entry     = c + 1;
        exp_pre   = -1;
        exp_act   = -1;
        if (!m_open) begin
            cur_tag = "R2 R3";
            exp_act = entry + ex;
            exp_col = exp_act + eff(cfg_trcd) + ex;
        end else if (m_row == row) begin
            cur_tag = "R7";
            exp_col = entry + ex;
        end else begin
            cur_tag = "R5 R6 R8";
            exp_pre = imax(entry, m_last_act + eff(cfg_tras)) + ex;
            exp_act = exp_pre + eff(cfg_trp) + ex;
            exp_col = exp_act + eff(cfg_trcd) + ex;
        end
        if (exp_act >= 0) m_last_act = exp_act;
        m_open     = 1'b1;
        m_row      = row;
        exp_row    = row;
        exp_colv   = col;
        exp_colcmd = wr ? 3'(CMD_WR) : 3'(CMD_RD);
        if (!wr) due_q.push_back(exp_col + eff(cfg_cl));
        do begin
            step();
            req_valid = 1'b0;
        end while (cyc < exp_col);
    endtask

    task automatic set_cfg(input int cl, input int rcd, input int rp, input int ras, input bit t2);
        cfg_cl    = TW'(cl);
        cfg_trcd  = TW'(rcd);
        cfg_trp   = TW'(rp);
        cfg_tras  = TW'(ras);
        cfg_cmd2t = t2;
    endtask

    task automatic directed();
        do_req(1'b0, 14'd5, 10'd7);    // no row open: ACT then RD
        do_req(1'b0, 14'd5, 10'd8);    // hit
        do_req(1'b1, 14'd9, 10'd3);    // miss held back by tRAS
        repeat (12) step();
        do_req(1'b0, 14'd2, 10'd1);    // miss after tRAS has run out
        do_req(1'b1, 14'd2, 10'd2);    // write hit
        repeat (20) step();            // drain read-valid pulses
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            do_req(1'($urandom_range(0, 1)), 14'($urandom_range(0, 3)), 10'($urandom_range(0, 1023)));
            repeat ($urandom_range(0, 3)) step();
        end
        repeat (20) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        req_valid = 1'b0;
        req_write = 1'b0;
        req_row   = '0;
        req_col   = '0;
        set_cfg(2, 3, 2, 6, 1'b0);
        do_reset();
        directed();

        set_cfg(2, 3, 2, 6, 1'b1);     // two-cycle command spacing, R9
        do_reset();
        directed();

        set_cfg(0, 0, 0, 0, 1'b0);     // R10: zero taken as one
        ptag = "R10 ";
        do_reset();
        directed();
        set_cfg(0, 0, 0, 0, 1'b1);
        do_reset();
        directed();
        ptag = "";

        set_cfg(5, 4, 3, 15, 1'b0);    // long tRAS and CL
        do_reset();
        directed();

        for (int k = 0; k < 6; k++) begin
            set_cfg($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                    $urandom_range(0, 15), 1'(k % 2));
            do_reset();
            random_run(40);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule